// File: doc/BRIEF.md
# Integer Execution Unit with Overflow Trap

This block is the 32-bit integer execution stage of a RISC core. Each accepted operation carries two operands, a 4-bit operation code and a 5-bit immediate shift amount. It covers add and subtract in a wrapping form and in a trapping form, shifts and rotates by an immediate amount or by a register amount, and counting of leading zeros or leading ones. Every beat also carries ten 1-bit condition results, signed and unsigned, computed from the two operands. The unit registers the result and the overflow outcome. When a trapping operation overflows, the destination write enable is dropped and a one-cycle trap strobe fires in its place.

Operations enter on a valid/ready stream. Results leave on a valid/ready stream that has one output register. `in_ready` is high when the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). An operation is accepted on a rising edge where `in_valid && in_ready`, and its result appears one cycle later. While `out_valid` is high and `out_ready` is low, every output field holds its value and no new operation is taken. With `out_ready` held high the unit accepts one operation per cycle.

Top module: `exu_int_unit`

## Requirements
- R1: Opcodes 0 (add) and 2 (subtract, a minus b) return the result modulo 2^32. They never raise a trap and always assert `out_wr_en` with the beat.
- R2: Opcode 1 (trapping add) flags overflow when a and b have the same sign and the sum's sign differs from it. An overflowing beat has `out_wr_en` low and `out_trap` high. Otherwise it behaves as opcode 0.
- R3: Opcode 3 (trapping subtract, a minus b) flags overflow when a and b differ in sign and the difference's sign differs from a. The beat is handled as in R2. Otherwise it behaves as opcode 2.
- R4: Opcodes 4, 5 and 6 shift b by `in_shamt`. Opcode 4 shifts left logically, 5 shifts right logically and 6 shifts right arithmetically.
- R5: Opcodes 8, 9 and 10 shift b in the same three ways, by the amount in bits 4:0 of a. Bits 31:5 of a have no effect.
- R6: Opcode 7 rotates b right by `in_shamt`, and opcode 11 rotates b right by a[4:0]. A rotate amount of 0 returns b unchanged.
- R7: Opcode 12 returns the count of leading zero bits of a, and opcode 13 the count of leading one bits of a, counting down from bit 31. Each returns 32 when every bit of a matches the counted value.
- R8: `out_cond` has these bits: bit 0 a==b, bit 1 a!=b, bit 2 signed a>=b, bit 3 signed a<b, bit 4 unsigned a>=b, bit 5 unsigned a<b, bit 6 a>=0, bit 7 a>0, bit 8 a<=0, bit 9 a<0 (the last four use signed a). All ten are computed for every opcode.
- R9: Opcodes 14 and 15 return a result of zero and raise no trap, and `out_wr_en` is asserted.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and all output fields hold their values. Every accepted operation produces exactly one output beat, and beats leave in the order the operations were accepted.
- R11: `out_trap` is high only in the cycle where an overflowing beat is accepted (`out_valid && out_ready`). It goes high once per overflowing operation.
- R12: After reset, `out_valid`, `out_wr_en` and `out_trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take the offered operation |
| in_op | input | 4 | Operation code (see R1 to R9) |
| in_a | input | 32 | First operand; also the variable shift amount and the counted operand |
| in_b | input | 32 | Second operand; the value that is shifted or rotated |
| in_shamt | input | 5 | Immediate shift or rotate amount |
| out_valid | output | 1 | A result beat is present |
| out_ready | input | 1 | The consumer takes the beat |
| out_result | output | 32 | Result of the operation |
| out_wr_en | output | 1 | Destination write enable; low on an overflowing beat |
| out_trap | output | 1 | Overflow trap strobe, high in the cycle the trapping beat is accepted |
| out_cond | output | 10 | Condition results (see R8) |

## Verification
The bound checker watches the stream protocol on every cycle: output fields hold during a stall, `in_ready` is low during a stall, and nothing is signalled without a beat. It also checks that a trap strobe never comes with a write enable and only appears on an accepted beat, that the paired condition bits are complementary, and that wrapping operations always write. The numeric content can only be shown by the bench scenarios, which compare each beat against a model in the bench. This covers the overflow boundaries at the most positive and most negative values, rotate by zero, variable amounts with high bits set in a, and leading counts of 0, 31 and 32. The bench also counts trap pulses under a stalling consumer, which shows that each pulse is tied to its beat.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_WRAP = 4'd0,
    OP_ADD_TRAP = 4'd1,
    OP_SUB_WRAP = 4'd2,
    OP_SUB_TRAP = 4'd3,
    OP_SLL_IMM  = 4'd4,
    OP_SRL_IMM  = 4'd5,
    OP_SRA_IMM  = 4'd6,
    OP_ROR_IMM  = 4'd7,
    OP_SLL_VAR  = 4'd8,
    OP_SRL_VAR  = 4'd9,
    OP_SRA_VAR  = 4'd10,
    OP_ROR_VAR  = 4'd11,
    OP_CLZ      = 4'd12,
    OP_CLO      = 4'd13,
    OP_RSV14    = 4'd14,
    OP_RSV15    = 4'd15
  } exu_op_e;

  // Shift kind taken from the low two opcode bits of the shift groups
  typedef enum logic [1:0] {
    SH_LL = 2'd0,
    SH_RL = 2'd1,
    SH_RA = 2'd2,
    SH_RR = 2'd3
  } shift_kind_e;

  localparam int NCOND   = 10;
  localparam int C_EQ    = 0;
  localparam int C_NE    = 1;
  localparam int C_GE    = 2;
  localparam int C_LT    = 3;
  localparam int C_GEU   = 4;
  localparam int C_LTU   = 5;
  localparam int C_GEZ   = 6;
  localparam int C_GTZ   = 7;
  localparam int C_LEZ   = 8;
  localparam int C_LTZ   = 9;

endpackage

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] ovf_vec;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
  end

  // add: same-sign operands, result sign differs; sub: different signs, result differs from a
  always_comb begin
    if (sub_i) ovf_vec = (a_i ^ b_i) & (a_i ^ sum_o);
    else       ovf_vec = ~(a_i ^ b_i) & (sum_o ^ b_i);
    ovf_o = ovf_vec[DATA_W-1];
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [SHW-1:0]    amt_i,
  input  shift_kind_e       kind_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] stage [SHW+1];

  assign stage[0] = val_i;

  // Log-depth barrel: stage k moves by 2^k when amount bit k is set.
  // Rotate by zero passes every stage untouched.
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [DATA_W-1:0] moved;
    always_comb begin
      unique case (kind_i)
        SH_LL: moved = stage[k] << S;
        SH_RL: moved = stage[k] >> S;
        SH_RA: moved = DATA_W'($signed(stage[k]) >>> S);
        default: moved = {stage[k][S-1:0], stage[k][DATA_W-1:S]};
      endcase
    end
    assign stage[k+1] = amt_i[k] ? moved : stage[k];
  end

  assign res_o = stage[SHW];
endmodule

// File: rtl/exu_lead_count.sv
module exu_lead_count #(
  parameter int DATA_W = 32,
  localparam int CW    = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              ones_i,
  output logic [CW-1:0]     cnt_o
);
  logic [DATA_W-1:0] norm;

  assign norm = ones_i ? ~val_i : val_i;

  // Highest set bit of the normalised word decides the count; none set gives DATA_W
  always_comb begin
    cnt_o = CW'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (norm[i]) cnt_o = CW'(DATA_W - 1 - i);
    end
  end
endmodule

// File: rtl/exu_compare.sv
module exu_compare
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [NCOND-1:0]  cond_o
);
  logic a_neg, a_zero, s_lt, u_lt;

  always_comb begin
    a_neg  = a_i[DATA_W-1];
    a_zero = (a_i == '0);
    s_lt   = $signed(a_i) < $signed(b_i);
    u_lt   = a_i < b_i;
    cond_o          = '0;
    cond_o[C_EQ]    = (a_i == b_i);
    cond_o[C_NE]    = (a_i != b_i);
    cond_o[C_GE]    = !s_lt;
    cond_o[C_LT]    = s_lt;
    cond_o[C_GEU]   = !u_lt;
    cond_o[C_LTU]   = u_lt;
    cond_o[C_GEZ]   = !a_neg;
    cond_o[C_GTZ]   = !a_neg && !a_zero;
    cond_o[C_LEZ]   = a_neg || a_zero;
    cond_o[C_LTZ]   = a_neg;
  end
endmodule

// File: rtl/exu_int_unit.sv
module exu_int_unit
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SHW   = $clog2(DATA_W),
  localparam int CW    = SHW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [SHW-1:0]    in_shamt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic              out_trap,
  output logic [NCOND-1:0]  out_cond
);
  exu_op_e           op;
  logic              is_sub;
  logic [DATA_W-1:0] sum;
  logic              ovf_raw;
  logic [SHW-1:0]    sh_amt;
  logic [DATA_W-1:0] sh_res;
  logic [CW-1:0]     lead_cnt;
  logic [NCOND-1:0]  cond;
  logic [DATA_W-1:0] res_d;
  logic              trap_d;
  logic              accept;

  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  logic              trap_q;
  logic [NCOND-1:0]  cond_q;

  assign op     = exu_op_e'(in_op);
  assign is_sub = (op == OP_SUB_WRAP) || (op == OP_SUB_TRAP);
  // Register-amount forms have opcode bit 3 set
  assign sh_amt = in_op[3] ? in_a[SHW-1:0] : in_shamt;

  exu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (in_a),
    .b_i   (in_b),
    .sub_i (is_sub),
    .sum_o (sum),
    .ovf_o (ovf_raw)
  );

  exu_shifter #(.DATA_W(DATA_W)) u_shift (
    .val_i  (in_b),
    .amt_i  (sh_amt),
    .kind_i (shift_kind_e'(in_op[1:0])),
    .res_o  (sh_res)
  );

  exu_lead_count #(.DATA_W(DATA_W)) u_lead (
    .val_i  (in_a),
    .ones_i (in_op[0]),
    .cnt_o  (lead_cnt)
  );

  exu_compare #(.DATA_W(DATA_W)) u_cmp (
    .a_i    (in_a),
    .b_i    (in_b),
    .cond_o (cond)
  );

  always_comb begin
    res_d  = '0;
    trap_d = 1'b0;
    unique case (op)
      OP_ADD_WRAP, OP_SUB_WRAP: res_d = sum;
      OP_ADD_TRAP, OP_SUB_TRAP: begin
        res_d  = sum;
        trap_d = ovf_raw;
      end
      OP_SLL_IMM, OP_SRL_IMM, OP_SRA_IMM, OP_ROR_IMM,
      OP_SLL_VAR, OP_SRL_VAR, OP_SRA_VAR, OP_ROR_VAR: res_d = sh_res;
      OP_CLZ, OP_CLO: res_d = DATA_W'(lead_cnt);
      default: res_d = '0;
    endcase
  end

  // Single output register with pass-through ready
  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      trap_q  <= 1'b0;
      cond_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (accept) begin
        res_q  <= res_d;
        trap_q <= trap_d;
        cond_q <= cond;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_cond   = cond_q;
  assign out_wr_en  = valid_q && !trap_q;
  assign out_trap   = valid_q && out_ready && trap_q;
endmodule

// File: rtl/exu_checker.sv
module exu_checker
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr_en,
  input logic              out_trap,
  input logic [NCOND-1:0]  out_cond
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cond)
                                && $stable(out_wr_en))
    else $error("stalled beat changed");

  assert_stall_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready)
    else $error("input accepted during stall");

  assert_trap_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> !out_wr_en)
    else $error("trap together with write enable");

  assert_trap_on_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_trap |-> out_valid && out_ready)
    else $error("trap without accepted beat");

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_wr_en && !out_trap)
    else $error("signal without beat");

  assert_wrap_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == 4'd0 || in_op == 4'd2) |=> out_wr_en)
    else $error("wrapping op did not write");

  assert_cond_pairs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cond[C_EQ] != out_cond[C_NE]) && (out_cond[C_GE] != out_cond[C_LT])
               && (out_cond[C_GEU] != out_cond[C_LTU]) && (out_cond[C_GEZ] != out_cond[C_LTZ])
               && (out_cond[C_GTZ] != out_cond[C_LEZ]))
    else $error("condition pair inconsistent");
endmodule

bind exu_int_unit exu_checker #(.DATA_W(DATA_W)) u_exu_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_wr_en  (out_wr_en),
  .out_trap   (out_trap),
  .out_cond   (out_cond)
);

// File: tb/tb_exu_int_unit.sv
module tb_exu_int_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [31:0] res;
    logic        wr;
    logic        trap;
    logic [9:0]  cond;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic        out_trap;
  logic [9:0]  out_cond;

  exp_t scb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   exp_traps = 0;
  int   seen_traps = 0;
  bit   stall_mode = 1'b0;
  bit   finished = 1'b0;
  int   cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exu_int_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_trap(out_trap), .out_cond(out_cond)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] model_cond(logic [31:0] a, logic [31:0] b);
    logic [9:0] c;
    c[0] = a == b;
    c[1] = a != b;
    c[2] = $signed(a) >= $signed(b);
    c[3] = $signed(a) <  $signed(b);
    c[4] = a >= b;
    c[5] = a <  b;
    c[6] = $signed(a) >= 0;
    c[7] = $signed(a) >  0;
    c[8] = $signed(a) <= 0;
    c[9] = $signed(a) <  0;
    return c;
  endfunction

  function automatic int lead(logic [31:0] v, bit ones);
    int n = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i] != ones) break;
      n++;
    end
    return n;
  endfunction

  function automatic exp_t model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                 logic [4:0] sh, string tag);
    exp_t e;
    logic [63:0] rr;
    logic [4:0]  n;
    longint sa, sb, sr;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e.res = '0; e.trap = 1'b0; e.tag = tag;
    e.cond = model_cond(a, b);
    n = op[3] ? a[4:0] : sh;
    case (op)
      4'd0, 4'd1: begin
        sr = sa + sb; e.res = a + b;
        e.trap = (op == 4'd1) && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
      end
      4'd2, 4'd3: begin
        sr = sa - sb; e.res = a - b;
        e.trap = (op == 4'd3) && (sr > 64'sd2147483647 || sr < -64'sd2147483648);
      end
      4'd4, 4'd8:  e.res = b << n;
      4'd5, 4'd9:  e.res = b >> n;
      4'd6, 4'd10: e.res = 32'($signed(b) >>> n);
      4'd7, 4'd11: begin rr = {b, b} >> n; e.res = rr[31:0]; end
      4'd12: e.res = 32'(lead(a, 1'b0));
      4'd13: e.res = 32'(lead(a, 1'b1));
      default: e.res = '0;
    endcase
    e.wr = !e.trap;
    return e;
  endfunction

  // Driver: offer one operation, push the expectation once it is accepted
  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] sh, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_shamt = sh;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e = model(op, a, b, sh, tag);
    if (e.trap) exp_traps++;
    scb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Consumer ready pattern
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor
  logic [31:0] held_res;
  bit          was_stalled = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (out_trap) seen_traps++;
      if (was_stalled && out_valid)
        check(out_result == held_res, "R10", "held result", out_result, held_res);
      was_stalled = out_valid && !out_ready;
      held_res = out_result;
      if (out_valid && out_ready) begin
        if (scb.size() == 0) begin
          check(1'b0, "R10", "unexpected beat", out_result, 32'h0);
        end else begin
          exp_t e;
          e = scb.pop_front();
          check(out_result == e.res, e.tag, "result", out_result, e.res);
          check(out_wr_en == e.wr, e.tag, "wr_en", 32'(out_wr_en), 32'(e.wr));
          check(out_trap == e.trap, e.tag, "trap", 32'(out_trap), 32'(e.trap));
          check(out_cond == e.cond, "R8", "cond", 32'(out_cond), 32'(e.cond));
        end
      end else begin
        check(!out_trap, "R11", "trap off beat", 32'(out_trap), 32'h0);
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(out_valid == 1'b0, "R12", "out_valid", 32'(out_valid), 32'h0);
    check(out_wr_en == 1'b0, "R12", "out_wr_en", 32'(out_wr_en), 32'h0);
    check(out_trap == 1'b0, "R12", "out_trap", 32'(out_trap), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 wrapping add/sub
    send(4'd0, 32'h7fffffff, 32'h1, 5'd0, "R1");
    send(4'd2, 32'h80000000, 32'h1, 5'd0, "R1");
    send(4'd0, 32'hffffffff, 32'hffffffff, 5'd0, "R1");
    // R2 trapping add
    send(4'd1, 32'h7fffffff, 32'h1, 5'd0, "R2");
    send(4'd1, 32'h80000000, 32'h80000000, 5'd0, "R2");
    send(4'd1, 32'h5, 32'hfffffffd, 5'd0, "R2");
    send(4'd1, 32'h7fffffff, 32'h80000000, 5'd0, "R2");
    // R3 trapping subtract
    send(4'd3, 32'h80000000, 32'h1, 5'd0, "R3");
    send(4'd3, 32'h7fffffff, 32'hffffffff, 5'd0, "R3");
    send(4'd3, 32'hffffffff, 32'hffffffff, 5'd0, "R3");
    send(4'd3, 32'h0, 32'h80000000, 5'd0, "R3");
    // R4 immediate shifts
    send(4'd4, 32'h0, 32'h8000000f, 5'd4, "R4");
    send(4'd5, 32'h0, 32'h8000000f, 5'd4, "R4");
    send(4'd6, 32'h0, 32'h8000000f, 5'd31, "R4");
    send(4'd6, 32'h0, 32'h4000000f, 5'd3, "R4");
    // R5 variable shifts, high bits of a ignored
    send(4'd8, 32'hffffffe3, 32'h00000101, 5'd0, "R5");
    send(4'd9, 32'h00000023, 32'hf0000000, 5'd7, "R5");
    send(4'd10, 32'h12345661, 32'h80000000, 5'd0, "R5");
    // R6 rotates
    send(4'd7, 32'h0, 32'h12345678, 5'd0, "R6");
    send(4'd7, 32'h0, 32'h12345678, 5'd8, "R6");
    send(4'd11, 32'h00000020, 32'hdeadbeef, 5'd9, "R6");
    send(4'd11, 32'h0000001f, 32'h80000001, 5'd0, "R6");
    // R7 leading counts
    send(4'd12, 32'h0, 32'h0, 5'd0, "R7");
    send(4'd12, 32'h1, 32'h0, 5'd0, "R7");
    send(4'd12, 32'h80000000, 32'h0, 5'd0, "R7");
    send(4'd13, 32'hffffffff, 32'h0, 5'd0, "R7");
    send(4'd13, 32'hf0000000, 32'h0, 5'd0, "R7");
    send(4'd13, 32'h7fffffff, 32'h0, 5'd0, "R7");
    // R8 comparisons across sign patterns
    send(4'd0, 32'h0, 32'h0, 5'd0, "R8");
    send(4'd0, 32'hfffffffe, 32'h3, 5'd0, "R8");
    send(4'd0, 32'h3, 32'hfffffffe, 5'd0, "R8");
    // R9 unused opcodes
    send(4'd14, 32'h7fffffff, 32'h1, 5'd3, "R9");
    send(4'd15, 32'h80000000, 32'h80000000, 5'd3, "R9");
    idle(3);

    // R10 / R11 under a stalling consumer
    stall_mode = 1'b1;
    for (int i = 0; i < 24; i++) begin
      send(4'(i % 16), 32'h7ffffff0 + 32'(i), 32'h80000000 - 32'(i * 3), 5'(i), "R10");
    end
    idle(10);
    stall_mode = 1'b0;
    idle(3);
    check(scb.size() == 0, "R10", "beats outstanding", 32'(scb.size()), 32'h0);
    check(seen_traps == exp_traps, "R11", "trap pulses", 32'(seen_traps), 32'(exp_traps));
    finish_run();
  end
endmodule